// File: doc/BRIEF.md
# Vectored Interrupt Enable Controller

This block gathers the six interrupt sources of a small 8-bit microcontroller core and hands the CPU one pending request together with its fixed 16-bit vector address. Two of the sources are active-low external pins. Three are timer overflow flags: timer 0, timer 1, and timer 2, whose overflow and external-capture flags share one source. The last is the serial port, whose receive and transmit flags also share one source. A global enable bit overrides every individual enable bit. When several enabled sources are pending, the one with the lowest vector address is presented.

Each external pin passes through a two-flop synchroniser. A per-pin mode bit then selects between two kinds of detection. In level mode the request follows the low pin. In edge mode a falling edge sets a latched flag, which stays set until the CPU acknowledges that vector. Software reaches the enable register and the mode register through a small register port. The port can load a value, or set, clear or toggle the bits given by a mask. An `irq_ack` pulse clears the edge flag of the external source that is granted at that moment, and nothing else.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable register and the mode register both read 0, no edge flag is held, and `irq_valid` is 0.
- R2: While enable bit 7 (global) is 0, `irq_valid` stays 0 whatever the other enable bits and the sources are.
- R3: With bit 7 set, each source is gated by its own enable bit. Bit 0 gates ext0, bit 1 timer0, bit 2 ext1, bit 3 timer1, bit 4 serial and bit 5 timer2.
- R4: The vector presented is 0x0003 for ext0, 0x000B for timer0, 0x0013 for ext1, 0x001B for timer1, 0x0023 for serial and 0x002B for timer2.
- R5: When several gated requests are pending, the one with the lowest vector address is presented.
- R6: The serial source is the OR of `ser_rx_done` and `ser_tx_done`. The timer2 source is the OR of `tmr2_ovf` and `tmr2_ext`.
- R7: Mode register bit k (bit 0 for ext0, bit 1 for ext1) equal to 0 selects level mode. A low pin raises the request after two clock edges and drops it two edges after the pin returns high.
- R8: A mode bit equal to 1 selects edge mode. A falling edge on the pin latches a request that is visible after three clock edges and stays set after the pin returns high. A pin that is already low and steady raises nothing.
- R9: A cycle with `irq_ack` high clears the edge flag of the granted external source only. It does not touch the flag of the other pin, a flag hidden behind a granted timer or serial request, or a level-mode request.
- R10: Enable bit 6 is reserved. It always reads 0, and no operation can set it.
- R11: Register port operations are selected by `wr_op`: 0 loads, 1 sets the masked bits, 2 clears them and 3 toggles them. Address 0 selects the enable register and address 1 the mode register. Only bits 1:0 of the mode register exist, and its other bits read 0. `rd_data` shows the register selected by `rd_addr` in the same cycle.
- R12: `irq_vector` is 0 whenever `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | Operation: 0 load, 1 set, 2 clear, 3 toggle |
| wr_addr | input | 1 | Write target: 0 enable, 1 mode |
| wr_data | input | 8 | Write value or bit mask |
| rd_addr | input | 1 | Read select: 0 enable, 1 mode |
| rd_data | output | 8 | Selected register contents |
| ext_n | input | 2 | External interrupt pins, active low, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external flag |
| ser_rx_done | input | 1 | Serial receive flag |
| ser_tx_done | input | 1 | Serial transmit flag |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_valid | output | 1 | A gated request is pending |
| irq_vector | output | 16 | Vector address of the presented request |

## Verification
The bench sweeps all 64 source patterns against all 256 enable values. This catches a global bit that fails to override, a swapped enable position, a wrong vector stride or a reversed priority order, each of which shows up as a wrong vector or a spurious valid for some pattern. The shared sources are driven by either partner or by both, so a design that wired only one flag of a pair misses requests. Directed sequences count clock edges after a pin moves, so a missing or an extra synchroniser stage is caught. They also acknowledge with the other pin's flag set, with a timer granted and in level mode, so an acknowledge that clears too widely loses a request, and one that clears nothing leaves the granted vector standing. Writes to the reserved bit and to the missing mode bits are read back to catch bits that stick.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_SRC     = 6;
    localparam int NUM_EXT     = 2;
    localparam int REG_W       = 8;
    localparam int GLOBAL_BIT  = 7;
    localparam int RSV_BIT     = 6;
    localparam int VEC_W       = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
    localparam logic [VEC_W-1:0] VEC_STEP = 16'h0008;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_TOG  = 2'd3
    } wr_op_e;

    // Slot of external pin k in the fixed priority order
    function automatic int ext_slot(int k);
        return 2 * k;
    endfunction

    function automatic logic [REG_W-1:0] apply_op(wr_op_e op,
                                                  logic [REG_W-1:0] cur,
                                                  logic [REG_W-1:0] val);
        logic [REG_W-1:0] r;
        case (op)
            OP_LOAD: r = val;
            OP_SET:  r = cur | val;
            OP_CLR:  r = cur & ~val;
            default: r = cur ^ val;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   flag;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic       fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.prev & ~st_q.sync[LAST];
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_n};
        st_d.prev = st_q.sync[LAST];
        st_d.flag = edge_mode & (fall | (st_q.flag & ~clr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: '1, prev: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req = edge_mode ? st_q.flag : ~st_q.sync[LAST];

    // R8
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> st_q.flag)
        else $error("edge fall not latched");

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_vec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_op,
    input  logic                wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                rd_addr,
    output logic [REG_W-1:0]    rd_data,
    output logic [REG_W-1:0]    en,
    output logic [NUM_EXT-1:0]  mode
);
    typedef struct packed {
        logic [REG_W-1:0]   en;
        logic [NUM_EXT-1:0] mode;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    wr_op_e     op;

    assign op = wr_op_e'(wr_op);

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_addr) begin
            st_d.en = apply_op(op, st_q.en, wr_data);
            st_d.en[RSV_BIT] = 1'b0;
        end
        if (wr_en && wr_addr) begin
            case (op)
                OP_LOAD: st_d.mode = wr_data[NUM_EXT-1:0];
                OP_SET:  st_d.mode = st_q.mode | wr_data[NUM_EXT-1:0];
                OP_CLR:  st_d.mode = st_q.mode & ~wr_data[NUM_EXT-1:0];
                default: st_d.mode = st_q.mode ^ wr_data[NUM_EXT-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en      = st_q.en;
    assign mode    = st_q.mode;
    assign rd_data = rd_addr ? REG_W'(st_q.mode) : st_q.en;

    // R11
    clr_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && op == OP_CLR) |=> ((st_q.en & $past(wr_data)) == '0))
        else $error("clear op left bits set");

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
#(
    parameter int N = NUM_SRC,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [VEC_W-1:0] vector
);
    logic [N-1:0] grant;

    always_comb begin
        grant = req & ~(req - N'(1));
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        valid  = |req;
        vector = valid ? VEC_BASE + VEC_STEP * VEC_W'(idx) : '0;
    end

    // R5
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (grant[idx] && $countones(grant) == 1))
        else $error("granted slot is not the lowest pending");

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_op,
    input  logic                wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                rd_addr,
    output logic [7:0]          rd_data,
    input  logic [1:0]          ext_n,
    input  logic                tmr0_ovf,
    input  logic                tmr1_ovf,
    input  logic                tmr2_ovf,
    input  logic                tmr2_ext,
    input  logic                ser_rx_done,
    input  logic                ser_tx_done,
    input  logic                irq_ack,
    output logic                irq_valid,
    output logic [15:0]         irq_vector
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [REG_W-1:0]   en;
    logic [NUM_EXT-1:0] mode;
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_EXT-1:0] ext_clr;
    logic [NUM_SRC-1:0] src;
    logic [NUM_SRC-1:0] gated;
    logic [IDX_W-1:0]   win_idx;

    irq_cfg_regs i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_op   (wr_op),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .en      (en),
        .mode    (mode)
    );

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        assign ext_clr[k] = irq_ack & irq_valid & (win_idx == IDX_W'(ext_slot(k)));

        irq_pin_detect #(.SYNC_STAGES(2)) i_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (mode[k]),
            .clr       (ext_clr[k]),
            .req       (ext_req[k])
        );
    end

    always_comb begin
        src   = {tmr2_ovf | tmr2_ext,
                 ser_rx_done | ser_tx_done,
                 tmr1_ovf,
                 ext_req[1],
                 tmr0_ovf,
                 ext_req[0]};
        gated = src & en[NUM_SRC-1:0] & {NUM_SRC{en[GLOBAL_BIT]}};
    end

    irq_prio_pick #(.N(NUM_SRC)) i_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (gated),
        .valid  (irq_valid),
        .idx    (win_idx),
        .vector (irq_vector)
    );

    // R2
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[GLOBAL_BIT] |-> !irq_valid)
        else $error("request raised with global enable off");

    // R12
    idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vector == '0))
        else $error("vector not zero while idle");

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_op = 2'd0;
    logic        wr_addr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_addr = 1'b0;
    logic [7:0]  rd_data;
    logic [1:0]  ext_n = 2'b11;
    logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_ovf = 1'b0, tmr2_ext = 1'b0;
    logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_valid;
    logic [15:0] irq_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ext_n(ext_n),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf), .tmr2_ext(tmr2_ext),
        .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [1:0] op, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_op = op; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic a, string tag, int exp);
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic out(string tag, int v, int vec);
        chk({tag, " valid"}, int'(irq_valid), v);
        chk({tag, " vector"}, int'(irq_vector), vec);
    endtask

    function automatic int exp_vec(logic [5:0] g);
        for (int i = 0; i < 6; i++) if (g[i]) return 3 + 8 * i;
        return 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(1'b0, "R1 enable reset", 0);
        rd(1'b1, "R1 mode reset", 0);
        out("R1 idle", 0, 0);

        // R11 operations on enable register; R10 reserved bit
        wr(1'b0, 2'd0, 8'h81); rd(1'b0, "R11 load", 8'h81);
        wr(1'b0, 2'd1, 8'h04); rd(1'b0, "R11 set", 8'h85);
        wr(1'b0, 2'd2, 8'h01); rd(1'b0, "R11 clear", 8'h84);
        wr(1'b0, 2'd3, 8'h0C); rd(1'b0, "R11 toggle", 8'h88);
        wr(1'b0, 2'd1, 8'h40); rd(1'b0, "R10 set reserved", 8'h88);
        wr(1'b0, 2'd3, 8'h40); rd(1'b0, "R10 toggle reserved", 8'h88);
        wr(1'b1, 2'd0, 8'hFF); rd(1'b1, "R11 mode load", 8'h03);
        rd(1'b0, "R11 enable untouched by mode write", 8'h88);
        wr(1'b1, 2'd2, 8'h01); rd(1'b1, "R11 mode clear", 8'h02);
        wr(1'b1, 2'd3, 8'h03); rd(1'b1, "R11 mode toggle", 8'h01);
        wr(1'b1, 2'd0, 8'h00); rd(1'b0, "R11 enable after mode writes", 8'h88);
        rd_addr = 1'b0;

        // Sweep R2 R3 R4 R5 R6 R10 R12: all sources against all enables (level mode)
        for (int s = 0; s < 64; s++) begin
            int v;
            v = s % 3;
            ext_n[0] = ~s[0];
            ext_n[1] = ~s[2];
            tmr0_ovf = s[1];
            tmr1_ovf = s[3];
            ser_rx_done = s[4] & (v != 1);
            ser_tx_done = s[4] & (v != 0);
            tmr2_ovf = s[5] & (v != 0);
            tmr2_ext = s[5] & (v != 1);
            cyc(3);
            for (int e = 0; e < 256; e++) begin
                logic [7:0] ev;
                logic [5:0] g;
                ev = 8'(e);
                g = 6'(s) & ev[5:0] & {6{ev[7]}};
                wr(1'b0, 2'd0, ev);
                chk("R3 R2 sweep valid", int'(irq_valid), int'(|g));
                chk("R4 R5 R6 R12 sweep vector", int'(irq_vector), exp_vec(g));
                chk("R10 sweep readback", int'(rd_data), int'(ev & 8'hBF));
            end
        end
        ext_n = 2'b11; tmr0_ovf = 0; tmr1_ovf = 0; tmr2_ovf = 0; tmr2_ext = 0;
        ser_rx_done = 0; ser_tx_done = 0;
        cyc(3);

        // R7 level timing
        wr(1'b0, 2'd0, 8'h85);
        ext_n[0] = 1'b0;
        cyc(1); out("R7 one edge after fall", 0, 0);
        cyc(1); out("R7 two edges after fall", 1, 3);
        ext_n[0] = 1'b1;
        cyc(1); out("R7 one edge after rise", 1, 3);
        cyc(1); out("R7 two edges after rise", 0, 0);

        // R8 edge mode
        wr(1'b1, 2'd0, 8'h03);
        ext_n[0] = 1'b0;
        cyc(2); out("R8 two edges after fall", 0, 0);
        cyc(1); out("R8 three edges after fall", 1, 3);
        ext_n[0] = 1'b1;
        cyc(4); out("R8 latched after release", 1, 3);

        // R9 ack clears only granted external flag
        ext_n[1] = 1'b0; cyc(2); ext_n[1] = 1'b1; cyc(4);
        out("R9 both flags", 1, 3);
        ack(); out("R9 ext1 survives ext0 ack", 1, 8'h13);
        ack(); out("R9 ext1 cleared", 0, 0);
        ack(); out("R9 ack with nothing pending", 0, 0);

        wr(1'b0, 2'd0, 8'h87);
        ext_n[1] = 1'b0; cyc(2); ext_n[1] = 1'b1; cyc(4);
        tmr0_ovf = 1'b1;
        cyc(1); out("R9 timer0 over ext1", 1, 8'h0B);
        ack(); out("R9 timer ack keeps timer", 1, 8'h0B);
        tmr0_ovf = 1'b0;
        cyc(1); out("R9 ext1 flag survives timer ack", 1, 8'h13);
        ack(); out("R9 ext1 then cleared", 0, 0);

        // R8 steady low pin in edge mode raises nothing
        ext_n[0] = 1'b0; cyc(4); ack(); out("R8 steady low cleared", 0, 0);
        cyc(4); out("R8 steady low no new request", 0, 0);
        ext_n[0] = 1'b1; cyc(3);

        // R9 ack in level mode leaves request
        wr(1'b1, 2'd0, 8'h00);
        ext_n[0] = 1'b0; cyc(3);
        out("R9 level pending", 1, 3);
        ack(); out("R9 level survives ack", 1, 3);
        ext_n[0] = 1'b1; cyc(3);

        // R6 shared sources
        wr(1'b0, 2'd0, 8'hB0);
        ser_tx_done = 1'b1; cyc(1); out("R6 serial via tx", 1, 8'h23);
        ser_tx_done = 1'b0; tmr2_ext = 1'b1; cyc(1); out("R6 timer2 via ext", 1, 8'h2B);
        ser_rx_done = 1'b1; cyc(1); out("R6 R5 serial over timer2", 1, 8'h23);
        wr(1'b0, 2'd2, 8'h80); out("R2 global off", 0, 0);

        finish_run();
    end
endmodule